// File: doc/BRIEF.md
# Load/Store Address Guard

This block sits between the address generation stage of a core and the data memory port. For every load or store it takes the raw byte address and the access width, clears the low address bits that the width requires to be zero, and raises the fault flags that apply to the access. The rules depend on which of two core flavours the block is serving (variant A or variant B), on the direction of the access, on its width, and on several fixed address windows in the upper part of the map.

The flags are independent. When an access meets more than one rule, every matching flag is raised. Deciding which fault wins, queuing faults and steering bytes are left to the surrounding pipeline. Each request produces a registered result exactly one clock after it is presented.

Top module: `ld_st_addr_guard`

## Requirements
- R1: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes and 4=16 bytes. These give alignment masks of 0, 1, 3, 7 and 15. The returned address is the request address with the masked low bits cleared, and the upper bits are unchanged.
- R2: Size codes 5, 6 and 7 are unsupported. They set the bad-size flag, apply a mask of zero so the address is returned unchanged, and raise no window, misalign or access-error flag.
- R3: On variant A (variant input 0), a load or store with any masked low bit set raises the access-error flag unless the alignment-exception mask input is 1. Variant A never raises the misalign flag or the access-exception flag.
- R4: On variant A, an 8-byte access whose corrected address lies in 0xFE800000..0xFEFFFFFF raises access error for a load and store error for a store. Accesses of any other width to that window raise nothing.
- R5: On variant B (variant input 1), a misaligned access raises the misalign flag whatever the mask input is. It does not raise access error by itself.
- R6: On variant B, an access of any width to 0xFEFF0600..0xFEFF7FFF or to 0xFE800000..0xFEFEFFFF raises access error for a load and store error for a store.
- R7: On variant B, any load or store to 0xFE000000..0xFE7FFFFF raises the access-exception flag, whatever the width.
- R8: Flags are not prioritised. When an access meets several rules, all of the matching flags are set together.
- R9: The response valid rises exactly one clock after a request valid, including for back-to-back requests. With no response valid, all flags are 0. A synchronous active-high reset clears the response valid and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Raw byte address |
| req_size | input | 3 | Width code (0..4 legal) |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_variant | input | 1 | Core flavour: 0 = A, 1 = B |
| align_exc_mask | input | 1 | Suppresses the variant A misalignment error |
| rsp_valid | output | 1 | Result strobe, one clock after the request |
| rsp_addr | output | 32 | Corrected, aligned address |
| rsp_misalign | output | 1 | Misaligned access (variant B) |
| rsp_acc_err | output | 1 | Data access error |
| rsp_acc_exc | output | 1 | Data access exception |
| rsp_store_err | output | 1 | Data store error |
| rsp_bad_size | output | 1 | Unsupported width code |

## Verification
Each window is probed at its first and last aligned address and just outside both ends. This separates a correct bound from an off-by-one bound or a swapped window. The same address is sent with both directions and both variants, which shows whether the direction and the variant steer a hit to the right flag. Misaligned requests are sent with the mask bit at both values on both variants, to show that masking applies only to variant A. Combined cases (misaligned accesses into a window) and illegal width codes show that flags accumulate and that the illegal-width path stays quiet.

// File: rtl/agd_pkg.sv
package agd_pkg;

  localparam int ADDR_W = 32;
  localparam int LOW_W  = 4;

  localparam logic [2:0] SZ_B1  = 3'd0;
  localparam logic [2:0] SZ_B2  = 3'd1;
  localparam logic [2:0] SZ_B4  = 3'd2;
  localparam logic [2:0] SZ_B8  = 3'd3;
  localparam logic [2:0] SZ_B16 = 3'd4;

  typedef struct packed {
    logic misalign;
    logic acc_err;
    logic acc_exc;
    logic store_err;
    logic bad_size;
  } agd_flags_t;

  function automatic logic size_legal(input logic [2:0] code);
    return code <= SZ_B16;
  endfunction

  function automatic logic [LOW_W-1:0] size_mask(input logic [2:0] code);
    logic [LOW_W-1:0] m;
    case (code)
      SZ_B2:   m = 4'h1;
      SZ_B4:   m = 4'h3;
      SZ_B8:   m = 4'h7;
      SZ_B16:  m = 4'hF;
      default: m = 4'h0;
    endcase
    return m;
  endfunction

  function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/agd_size_decode.sv
module agd_size_decode
  import agd_pkg::*;
(
  input  logic [2:0]       size_code,
  output logic [LOW_W-1:0] mask,
  output logic             bad,
  output logic             is_dword
);
  always_comb begin
    bad      = !size_legal(size_code);
    mask     = size_mask(size_code);
    is_dword = (size_code == SZ_B8);
  end
endmodule

// File: rtl/agd_window_match.sv
module agd_window_match
  import agd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LO = '0,
  parameter logic [ADDR_W-1:0] HI = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb hit = in_range(addr, LO, HI);
endmodule

// File: rtl/agd_rule_engine.sv
module agd_rule_engine
  import agd_pkg::*;
#(
  parameter int N_WIN = 4
) (
  input  logic             variant_b,
  input  logic             is_store,
  input  logic             is_dword,
  input  logic             misaligned,
  input  logic             bad,
  input  logic             emask,
  input  logic [N_WIN-1:0] hits,
  output agd_flags_t       flags
);
  // hit index map: 0 = variant A wide-access window, 1/2 = variant B
  // error windows, 3 = variant B exception window
  logic [N_WIN-1:0] gh;
  logic             a_win, b_err_win;

  always_comb begin
    gh        = bad ? '0 : hits;
    a_win     = is_dword && gh[0];
    b_err_win = gh[1] || gh[2];
    flags     = '0;
    flags.bad_size = bad;
    if (!variant_b) begin
      flags.acc_err   = (misaligned && !emask) || (a_win && !is_store);
      flags.store_err = a_win && is_store;
    end else begin
      flags.misalign  = misaligned;
      flags.acc_err   = b_err_win && !is_store;
      flags.store_err = b_err_win && is_store;
      flags.acc_exc   = gh[3];
    end
  end
endmodule

// File: rtl/ld_st_addr_guard.sv
module ld_st_addr_guard
  import agd_pkg::*;
#(
  parameter int                         N_WIN  = 4,
  parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_LO = {32'hFE000000, 32'hFE800000,
                                                  32'hFEFF0600, 32'hFE800000},
  parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_HI = {32'hFE7FFFFF, 32'hFEFEFFFF,
                                                  32'hFEFF7FFF, 32'hFEFFFFFF}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_store,
  input  logic              req_variant,
  input  logic              align_exc_mask,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_misalign,
  output logic              rsp_acc_err,
  output logic              rsp_acc_exc,
  output logic              rsp_store_err,
  output logic              rsp_bad_size
);
  logic [LOW_W-1:0]  low_mask;
  logic              size_bad, size_dword;
  logic              misaligned;
  logic [ADDR_W-1:0] fixed_addr;
  logic [N_WIN-1:0]  win_hit;
  agd_flags_t        cur_flags;
  agd_flags_t        flags_q;

  agd_size_decode u_size (
    .size_code (req_size),
    .mask      (low_mask),
    .bad       (size_bad),
    .is_dword  (size_dword)
  );

  always_comb begin
    misaligned = |(req_addr[LOW_W-1:0] & low_mask);
    fixed_addr = {req_addr[ADDR_W-1:LOW_W], req_addr[LOW_W-1:0] & ~low_mask};
  end

  // window comparisons use the corrected address
  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    agd_window_match #(.LO(WIN_LO[g]), .HI(WIN_HI[g])) u_win (
      .addr (fixed_addr),
      .hit  (win_hit[g])
    );
  end

  agd_rule_engine #(.N_WIN(N_WIN)) u_rules (
    .variant_b  (req_variant),
    .is_store   (req_store),
    .is_dword   (size_dword),
    .misaligned (misaligned),
    .bad        (size_bad),
    .emask      (align_exc_mask),
    .hits       (win_hit),
    .flags      (cur_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      flags_q   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= fixed_addr;
        flags_q  <= cur_flags;
      end else begin
        flags_q  <= '0;
      end
    end
  end

  always_comb begin
    rsp_misalign  = flags_q.misalign;
    rsp_acc_err   = flags_q.acc_err;
    rsp_acc_exc   = flags_q.acc_exc;
    rsp_store_err = flags_q.store_err;
    rsp_bad_size  = flags_q.bad_size;
  end
endmodule

// File: rtl/agd_checker.sv
module agd_checker
  import agd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic              req_store,
  input logic              req_variant,
  input logic              align_exc_mask,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_misalign,
  input logic              rsp_acc_err,
  input logic              rsp_acc_exc,
  input logic              rsp_store_err,
  input logic              rsp_bad_size
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_misalign || rsp_acc_err || rsp_acc_exc || rsp_store_err || rsp_bad_size)); // R9
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_addr[LOW_W-1:0] & size_mask($past(req_size))) == '0)); // R1
  AST_ADDR_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_addr[ADDR_W-1:LOW_W] == $past(req_addr[ADDR_W-1:LOW_W]))); // R1
  AST_BAD_SIZE_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_bad_size |-> (!rsp_misalign && !rsp_acc_err && !rsp_acc_exc && !rsp_store_err
                      && rsp_addr == $past(req_addr))); // R2
  AST_A_NO_B_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_variant)) |-> (!rsp_misalign && !rsp_acc_exc)); // R3
  AST_A_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_variant) && $past(align_exc_mask) && $past(req_size) != SZ_B8)
      |-> !rsp_acc_err); // R4
  AST_LOAD_NO_STORE_ERR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_store)) |-> !rsp_store_err); // R6
  AST_B_STORE_NO_ACC_ERR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_variant) && $past(req_store)) |-> !rsp_acc_err); // R6
endmodule

bind ld_st_addr_guard agd_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .req_size       (req_size),
  .req_store      (req_store),
  .req_variant    (req_variant),
  .align_exc_mask (align_exc_mask),
  .rsp_valid      (rsp_valid),
  .rsp_addr       (rsp_addr),
  .rsp_misalign   (rsp_misalign),
  .rsp_acc_err    (rsp_acc_err),
  .rsp_acc_exc    (rsp_acc_exc),
  .rsp_store_err  (rsp_store_err),
  .rsp_bad_size   (rsp_bad_size)
);

// File: tb/ld_st_addr_guard_test.sv
module ld_st_addr_guard_test;
  // flag vector order: {misalign, acc_err, acc_exc, store_err, bad_size}
  localparam logic [4:0] F_NONE = 5'b00000;
  localparam logic [4:0] F_MIS  = 5'b10000;
  localparam logic [4:0] F_ERR  = 5'b01000;
  localparam logic [4:0] F_EXC  = 5'b00100;
  localparam logic [4:0] F_SERR = 5'b00010;
  localparam logic [4:0] F_BAD  = 5'b00001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_store = 1'b0;
  logic        req_variant = 1'b0;
  logic        align_exc_mask = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_misalign, rsp_acc_err, rsp_acc_exc, rsp_store_err, rsp_bad_size;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ld_st_addr_guard uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_variant(req_variant),
    .align_exc_mask(align_exc_mask), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_misalign(rsp_misalign), .rsp_acc_err(rsp_acc_err), .rsp_acc_exc(rsp_acc_exc),
    .rsp_store_err(rsp_store_err), .rsp_bad_size(rsp_bad_size)
  );

  function automatic logic [4:0] got_flags();
    return {rsp_misalign, rsp_acc_err, rsp_acc_exc, rsp_store_err, rsp_bad_size};
  endfunction

  // drive one request at a negedge, check the result at the following negedge
  task automatic access(input string req, input logic var_b, input logic st,
                        input logic [2:0] sz, input logic [31:0] a, input logic msk,
                        input logic [31:0] exp_a, input logic [4:0] exp_f);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_store = st;
    req_variant = var_b; align_exc_mask = msk;
    @(posedge clk); @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_addr !== exp_a || got_flags() !== exp_f) begin
      failures++;
      $display("FAIL %s addr=%h: got valid=%b addr=%h flags=%b, expected valid=1 addr=%h flags=%b",
               req, a, rsp_valid, rsp_addr, got_flags(), exp_a, exp_f);
    end
    req_valid = 1'b0;
  endtask

  task automatic idle_check(input string req);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || got_flags() !== F_NONE) begin
      failures++;
      $display("FAIL %s idle: got valid=%b flags=%b, expected valid=0 flags=00000",
               req, rsp_valid, got_flags());
    end
  endtask

  task automatic t_reset();
    checks++;
    if (rsp_valid !== 1'b0 || got_flags() !== F_NONE) begin
      failures++;
      $display("FAIL R9 reset: got valid=%b flags=%b, expected 0/00000", rsp_valid, got_flags());
    end
  endtask

  task automatic t_sizes();
    access("R1 1B",  0, 0, 3'd0, 32'h0000_1003, 0, 32'h0000_1003, F_NONE);
    access("R1 2B",  0, 0, 3'd1, 32'h0000_1002, 0, 32'h0000_1002, F_NONE);
    access("R1 4B",  0, 1, 3'd2, 32'h0000_1008, 0, 32'h0000_1008, F_NONE);
    access("R1 8B",  0, 0, 3'd3, 32'hABCD_0010, 0, 32'hABCD_0010, F_NONE);
    access("R1 16B", 1, 0, 3'd4, 32'h1234_567F, 0, 32'h1234_5670, F_MIS);
    access("R1 8B fix", 1, 1, 3'd3, 32'h0000_0FFF, 0, 32'h0000_0FF8, F_MIS);
  endtask

  task automatic t_bad_size();
    access("R2 code5", 1, 0, 3'd5, 32'hFE00_0003, 0, 32'hFE00_0003, F_BAD);
    access("R2 code7", 0, 1, 3'd7, 32'hFE80_0001, 0, 32'hFE80_0001, F_BAD);
    access("R2 code6", 1, 1, 3'd6, 32'hFEFF_0601, 0, 32'hFEFF_0601, F_BAD);
  endtask

  task automatic t_a_align();
    access("R3 unmasked", 0, 0, 3'd2, 32'h0000_0102, 0, 32'h0000_0100, F_ERR);
    access("R3 masked",   0, 1, 3'd2, 32'h0000_0102, 1, 32'h0000_0100, F_NONE);
    access("R3 st unmasked", 0, 1, 3'd1, 32'h0000_0203, 0, 32'h0000_0202, F_ERR);
    access("R3 A exc win", 0, 0, 3'd0, 32'hFE00_0000, 0, 32'hFE00_0000, F_NONE);
  endtask

  task automatic t_a_window();
    access("R4 ld lo",   0, 0, 3'd3, 32'hFE80_0000, 0, 32'hFE80_0000, F_ERR);
    access("R4 st hi",   0, 1, 3'd3, 32'hFEFF_FFF8, 0, 32'hFEFF_FFF8, F_SERR);
    access("R4 4B in",   0, 0, 3'd2, 32'hFE90_0000, 0, 32'hFE90_0000, F_NONE);
    access("R4 16B in",  0, 1, 3'd4, 32'hFE90_0000, 0, 32'hFE90_0000, F_NONE);
    access("R4 below",   0, 0, 3'd3, 32'hFE7F_FFF8, 0, 32'hFE7F_FFF8, F_NONE);
    access("R4 above",   0, 1, 3'd3, 32'hFF00_0000, 0, 32'hFF00_0000, F_NONE);
  endtask

  task automatic t_b_align();
    access("R5 mask0", 1, 0, 3'd1, 32'h0000_0011, 0, 32'h0000_0010, F_MIS);
    access("R5 mask1", 1, 1, 3'd2, 32'h0000_0013, 1, 32'h0000_0010, F_MIS);
  endtask

  task automatic t_b_err();
    access("R6 ld lo1",  1, 0, 3'd2, 32'hFEFF_0600, 0, 32'hFEFF_0600, F_ERR);
    access("R6 st hi1",  1, 1, 3'd0, 32'hFEFF_7FFF, 0, 32'hFEFF_7FFF, F_SERR);
    access("R6 gap",     1, 0, 3'd2, 32'hFEFF_05FC, 0, 32'hFEFF_05FC, F_NONE);
    access("R6 above1",  1, 0, 3'd0, 32'hFEFF_8000, 0, 32'hFEFF_8000, F_NONE);
    access("R6 st lo2",  1, 1, 3'd1, 32'hFE80_0000, 0, 32'hFE80_0000, F_SERR);
    access("R6 ld hi2",  1, 0, 3'd0, 32'hFEFE_FFFF, 0, 32'hFEFE_FFFF, F_ERR);
  endtask

  task automatic t_b_exc();
    access("R7 ld lo",  1, 0, 3'd0, 32'hFE00_0000, 0, 32'hFE00_0000, F_EXC);
    access("R7 st hi",  1, 1, 3'd4, 32'hFE7F_FFF0, 0, 32'hFE7F_FFF0, F_EXC);
    access("R7 below",  1, 0, 3'd2, 32'hFDFF_FFFC, 0, 32'hFDFF_FFFC, F_NONE);
    access("R7 after",  1, 0, 3'd2, 32'hFE80_0000, 0, 32'hFE80_0000, F_ERR);
  endtask

  task automatic t_combos();
    access("R8 B mis+err",  1, 0, 3'd3, 32'hFEFF_0605, 0, 32'hFEFF_0600, F_MIS | F_ERR);
    access("R8 B mis+exc",  1, 1, 3'd2, 32'hFE00_0001, 0, 32'hFE00_0000, F_MIS | F_EXC);
    access("R8 A mis+serr", 0, 1, 3'd3, 32'hFE80_0003, 0, 32'hFE80_0000, F_ERR | F_SERR);
  endtask

  task automatic t_timing();
    idle_check("R9 gap");
    access("R9 b2b 1", 1, 0, 3'd0, 32'hFE00_0010, 0, 32'hFE00_0010, F_EXC);
    access("R9 b2b 2", 0, 0, 3'd0, 32'h0000_0010, 0, 32'h0000_0010, F_NONE);
    idle_check("R9 after");
    req_valid = 1'b1; req_variant = 1'b1; req_addr = 32'hFE00_0000; req_size = 3'd0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    t_reset();
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_sizes();
    t_bad_size();
    t_a_align();
    t_a_window();
    t_b_align();
    t_b_err();
    t_b_exc();
    t_combos();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule